// File: doc/BRIEF.md
# Dual-Mode Serial Memory Mode Controller

This block sits in front of a small byte memory and arbitrates one open-drain data line between two serial schemes. Out of reset it is in a transmit-only mode. In that mode every rising edge on a dedicated output clock places the next stored bit on the line. The walk starts at byte 0, sends each byte most significant bit first, and wraps from the last byte back to byte 0.

The first qualified falling edge on the two-wire bus clock moves the block into a bidirectional mode. In that mode an attached two-wire slave owns the line. The switch is one-way: only reset brings transmit-only mode back. In bidirectional mode the block gates the slave's write commits with the level of the transmit clock. After an accepted commit it runs a fixed-length write-busy window. During that window the slave is told to stay silent and any pull-down it requests is blocked, so the line stays released.

The line is never driven high. The single line output is a pull-low enable. Both clock pins are asynchronous and are brought into the system clock domain through synchronizer stages.

Top module: `dual_mode_serial_ctrl`

## Requirements
- R1: After reset, `mode_bidir_o` is 0, `wr_busy_o` is 0, `sda_pull_o` is 0 (line released), `slv_en_o` is 0 and `mem_addr_o` is 0.
- R2: In transmit-only mode, each rising edge on `vclk_i` puts the next memory bit on the line, no later than three system clocks after the edge. Bytes are taken from address 0 upward and each byte is sent bit 7 first. A 0 bit gives `sda_pull_o`=1 and a 1 bit gives `sda_pull_o`=0.
- R3: After bit 0 of the last byte (address 2^ADDR_W-1), the next transmit clock edge sends bit 7 of address 0.
- R4: A falling edge on `scl_i`, after the synchronized level was high for at least MIN_HIGH (2) system clocks, sets `mode_bidir_o` to 1 within three system clocks.
- R5: If `scl_i` is high for only one system clock before falling, the mode does not change.
- R6: Once `mode_bidir_o` is 1, it stays 1 until reset, whatever `scl_i` and `vclk_i` do. Transmit clock edges no longer move `mem_addr_o` or affect the line.
- R7: In bidirectional mode and not busy, `slv_en_o` is 1 and `sda_pull_o` equals `slv_pull_i`.
- R8: A commit pulse on `slv_wr_commit_i` while the synchronized `vclk_i` is low produces no `mem_we_o` and no busy window.
- R9: A commit pulse in bidirectional mode, with `vclk_i` high and not busy, raises `mem_we_o` in the same cycle. `wr_busy_o` then stays high for exactly WR_CYCLES clocks, starting the next cycle.
- R10: While `wr_busy_o` is 1: `slv_en_o` is 0, `sda_pull_o` is 0 whatever `slv_pull_i` is, and commits produce no `mem_we_o` and do not lengthen the window.
- R11: In transmit-only mode, commit pulses produce no `mem_we_o` and no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vclk_i | input | 1 | Transmit-only output clock (asynchronous) |
| scl_i | input | 1 | Two-wire bus clock (asynchronous) |
| mem_data_i | input | DATA_W | Byte read from memory at `mem_addr_o` |
| slv_pull_i | input | 1 | Slave requests the line pulled low |
| slv_wr_commit_i | input | 1 | Slave saw a stop ending a write sequence |
| mem_addr_o | output | ADDR_W | Serializer read address |
| mem_we_o | output | 1 | Write strobe to the memory array |
| slv_en_o | output | 1 | Slave may respond on the bus |
| sda_pull_o | output | 1 | Open-drain pull-low enable for the data line |
| mode_bidir_o | output | 1 | 1 when in bidirectional mode |
| wr_busy_o | output | 1 | 1 during the internal write cycle |

## Verification
The bench clocks the whole memory out bit by bit and keeps going past the last byte. A design with a wrong bit order, a wrong start address or a broken wrap gives a wrong line value at a known index. It drives two-wire clock highs of exactly one and exactly two system clocks. A filter that is off by one then either switches on the glitch or misses the shortest valid edge. The busy window is measured to the exact cycle and a commit is injected inside it. A timer that reloads would show a longer window, and a leaky gate would show a write strobe or a line pull-down while busy. Commits are also sent with the transmit clock low and in transmit-only mode, where a missing gate shows up as a strobe.

// File: rtl/dms_pkg.sv
// Shared types for the dual-mode serial controller.
// Assumes: nothing beyond IEEE 1800-2017.
package dms_pkg;
    typedef enum logic {
        MODE_TX    = 1'b0,
        MODE_BIDIR = 1'b1
    } dms_mode_e;
endpackage

// File: rtl/dms_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; reset value is 0.
module dms_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o
);
    logic [STAGES-1:0] chain;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage re-registers its predecessor.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign lvl_o = chain[STAGES-1];
endmodule

// File: rtl/dms_mode_fsm.sv
// Sticky mode register. It leaves transmit-only mode on the first
// falling edge of the synchronized bus clock that was preceded by
// at least MIN_HIGH high cycles. Only reset returns it.
// Assumes: scl_lvl is already synchronous to clk.
module dms_mode_fsm
    import dms_pkg::*;
#(
    parameter int MIN_HIGH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_lvl,
    output dms_mode_e mode_o
);
    localparam int HC_W = $clog2(MIN_HIGH + 1);

    logic            scl_prev;
    logic [HC_W-1:0] high_cnt;
    logic            fall_ok;

    // Remember the previous level and count consecutive high cycles (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b0;
            high_cnt <= '0;
        end else begin
            scl_prev <= scl_lvl;
            if (!scl_lvl)
                high_cnt <= '0;
            else if (high_cnt < HC_W'(MIN_HIGH))
                high_cnt <= high_cnt + HC_W'(1);
        end
    end

    assign fall_ok = scl_prev && !scl_lvl && (high_cnt >= HC_W'(MIN_HIGH));

    // One-way transition into bidirectional mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_o <= MODE_TX;
        else if (fall_ok) mode_o <= MODE_BIDIR;
    end
endmodule

// File: rtl/dms_tx_serial.sv
// Transmit-only serializer. Each rising edge of the synchronized
// transmit clock latches the bit at the pointer and advances it.
// Order is bytes upward from 0, each MSB first, wrapping at the end.
// Assumes: DATA_W is a power of two; memory read is combinational.
module dms_tx_serial #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vclk_lvl,
    input  logic              active_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              pull_o
);
    localparam int               BIT_W   = $clog2(DATA_W);
    localparam int               PTR_W   = ADDR_W + BIT_W;
    localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(DATA_W - 1);

    logic             vclk_prev;
    logic [PTR_W-1:0] ptr;
    logic [BIT_W-1:0] bit_idx;
    logic             tx_bit;
    logic             tx_valid;
    logic             step;

    assign bit_idx    = ptr[BIT_W-1:0];
    assign mem_addr_o = ptr[PTR_W-1:BIT_W];
    assign step       = active_i && vclk_lvl && !vclk_prev;

    // Track the previous transmit clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vclk_prev <= 1'b0;
        else        vclk_prev <= vclk_lvl;
    end

    // Latch the current bit and advance the wrapping pointer on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            tx_bit   <= 1'b1;
            tx_valid <= 1'b0;
        end else if (step) begin
            tx_bit   <= mem_data_i[MSB_IDX - bit_idx];
            tx_valid <= 1'b1;
            ptr      <= ptr + PTR_W'(1);
        end
    end

    assign pull_o = active_i && tx_valid && !tx_bit;
endmodule

// File: rtl/dms_wr_timer.sv
// Write gate and busy timer. It accepts a commit only in bidirectional
// mode, with the transmit clock high and no cycle running, and then
// holds busy for WR_CYCLES clocks.
// Assumes: commit_i is a single-cycle pulse from the slave.
module dms_wr_timer #(
    parameter int WR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit_i,
    input  logic bidir_i,
    input  logic vclk_lvl,
    output logic we_o,
    output logic busy_o
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    assign busy_o = (remain != '0);
    assign we_o   = commit_i && bidir_i && vclk_lvl && !busy_o;

    // Load on an accepted commit, then count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      remain <= '0;
        else if (we_o)   remain <= CNT_W'(WR_CYCLES);
        else if (busy_o) remain <= remain - CNT_W'(1);
    end
endmodule

// File: rtl/dual_mode_serial_ctrl.sv
// Top of the dual-mode serial memory controller. It synchronizes both
// clock pins, keeps the sticky mode, and selects which source may pull
// the shared open-drain line low. The line is never driven high.
// Assumes: the slave byte protocol and the memory array live outside.
module dual_mode_serial_ctrl
    import dms_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int WR_CYCLES   = 500000,
    parameter int MIN_HIGH    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vclk_i,
    input  logic              scl_i,
    input  logic [DATA_W-1:0] mem_data_i,
    input  logic              slv_pull_i,
    input  logic              slv_wr_commit_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic              slv_en_o,
    output logic              sda_pull_o,
    output logic              mode_bidir_o,
    output logic              wr_busy_o
);
    logic      vclk_lvl;
    logic      scl_lvl;
    dms_mode_e mode;
    logic      bidir;
    logic      tx_pull;

    dms_sync #(.STAGES(SYNC_STAGES)) u_vclk_sync (
        .clk(clk), .rst_n(rst_n), .async_i(vclk_i), .lvl_o(vclk_lvl)
    );

    dms_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .async_i(scl_i), .lvl_o(scl_lvl)
    );

    dms_mode_fsm #(.MIN_HIGH(MIN_HIGH)) u_mode (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .mode_o(mode)
    );

    assign bidir = (mode == MODE_BIDIR);

    dms_tx_serial #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .vclk_lvl(vclk_lvl), .active_i(!bidir),
        .mem_data_i(mem_data_i), .mem_addr_o(mem_addr_o), .pull_o(tx_pull)
    );

    dms_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_wr (
        .clk(clk), .rst_n(rst_n), .commit_i(slv_wr_commit_i), .bidir_i(bidir),
        .vclk_lvl(vclk_lvl), .we_o(mem_we_o), .busy_o(wr_busy_o)
    );

    // Line owner select: serializer in transmit-only mode, gated slave otherwise.
    always_comb begin
        if (bidir) sda_pull_o = slv_pull_i && !wr_busy_o;
        else       sda_pull_o = tx_pull;
    end

    assign slv_en_o     = bidir && !wr_busy_o;
    assign mode_bidir_o = bidir;
endmodule

// File: rtl/dms_ctrl_chk.sv
// Checker bound to the top; it watches port-level relations over time.
// Assumes: synchronous active-low reset on rst_n.
module dms_ctrl_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_bidir_o,
    input logic              mem_we_o,
    input logic              wr_busy_o,
    input logic              sda_pull_o,
    input logic              slv_en_o,
    input logic [ADDR_W-1:0] mem_addr_o
);
    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bidir_o |=> mode_bidir_o); // R6
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bidir_o |=> $stable(mem_addr_o)); // R6
    AST_WE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> wr_busy_o); // R9
    AST_BUSY_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy_o |-> !mem_we_o); // R10
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy_o |-> (!sda_pull_o && !slv_en_o)); // R10
    AST_TX_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bidir_o |-> (!mem_we_o && !wr_busy_o)); // R11
endmodule

bind dual_mode_serial_ctrl dms_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_bidir_o(mode_bidir_o),
    .mem_we_o(mem_we_o), .wr_busy_o(wr_busy_o), .sda_pull_o(sda_pull_o),
    .slv_en_o(slv_en_o), .mem_addr_o(mem_addr_o)
);

// File: tb/tb_dual_mode_serial_ctrl.sv
// Self-checking bench: full serial sweep with wrap, mode filter
// boundaries, write gating and an exact busy window length.
module tb_dual_mode_serial_ctrl;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int WR_CYC = 23;
    localparam int NBITS  = (1 << ADDR_W) * DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vclk = 1'b0;
    logic              scl = 1'b0;
    logic [DATA_W-1:0] mem_data;
    logic              slv_pull = 1'b0;
    logic              commit = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we, slv_en, sda_pull, mode_bidir, wr_busy;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dual_mode_serial_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .vclk_i(vclk), .scl_i(scl),
        .mem_data_i(mem_data), .slv_pull_i(slv_pull), .slv_wr_commit_i(commit),
        .mem_addr_o(mem_addr), .mem_we_o(mem_we), .slv_en_o(slv_en),
        .sda_pull_o(sda_pull), .mode_bidir_o(mode_bidir), .wr_busy_o(wr_busy)
    );

    function automatic logic [7:0] memf(input logic [ADDR_W-1:0] a);
        logic [15:0] t;
        t = {9'd0, a} * 16'd29 + 16'd7;
        return t[7:0];
    endfunction

    assign mem_data = memf(mem_addr);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic vpulse();
        vclk = 1'b1; cyc(3);
        vclk = 1'b0; cyc(3);
    endtask

    function automatic logic exp_pull(input int n);
        int   idx;
        logic b;
        idx = n % NBITS;
        b = memf(ADDR_W'(idx / DATA_W))[DATA_W - 1 - (idx % DATA_W)];
        return !b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int bad;
        int cnt;
        logic [ADDR_W-1:0] held;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 mode", mode_bidir, 0);
        chk("R1 busy", wr_busy, 0);
        chk("R1 line", sda_pull, 0);
        chk("R1 slv_en", slv_en, 0);
        chk("R1 addr", mem_addr, 0);

        // R11: commit in transmit-only mode with vclk high (first pulse's high phase)
        vclk = 1'b1; cyc(3);
        commit = 1'b1; #1;
        chk("R11 we", mem_we, 0);
        cyc(1); commit = 1'b0;
        chk("R11 busy", wr_busy, 0);
        vclk = 1'b0; cyc(3);
        chk("R2 bit 0", sda_pull, exp_pull(0));

        // R2 / R3: full sweep past the wrap point
        bad = 0;
        for (int n = 1; n < NBITS + 2 * DATA_W; n++) begin
            vpulse();
            if (sda_pull !== exp_pull(n)) begin
                bad++;
                if (bad < 4) $display("FAIL %s: got %0h expected %0h",
                                      (n >= NBITS) ? "R3" : "R2", sda_pull, exp_pull(n));
            end
        end
        checks++;
        if (bad != 0) fails++;
        chk("R3 addr after wrap", mem_addr, 2);

        // R5: one-cycle high on scl is filtered
        scl = 1'b1; cyc(1); scl = 1'b0; cyc(5);
        chk("R5 glitch", mode_bidir, 0);

        // R4: two-cycle high is the shortest valid edge
        scl = 1'b1; cyc(2); scl = 1'b0; cyc(4);
        chk("R4 mode", mode_bidir, 1);
        chk("R7 slv_en", slv_en, 1);

        // R6: sticky mode, serializer frozen
        held = mem_addr;
        for (int k = 0; k < 4; k++) begin
            scl = 1'b1; cyc(3); scl = 1'b0; cyc(3);
            vpulse();
        end
        chk("R6 mode", mode_bidir, 1);
        chk("R6 addr", mem_addr, held);
        chk("R6 line", sda_pull, 0);

        // R7: slave owns the line
        slv_pull = 1'b1; #1;
        chk("R7 pull", sda_pull, 1);
        cyc(1); slv_pull = 1'b0; #1;
        chk("R7 release", sda_pull, 0);

        // R8: vclk low inhibits writes
        cyc(1);
        commit = 1'b1; #1;
        chk("R8 we", mem_we, 0);
        cyc(1); commit = 1'b0;
        chk("R8 busy", wr_busy, 0);

        // R9 / R10: accepted write and exact busy window
        vclk = 1'b1; cyc(4);
        commit = 1'b1; #1;
        chk("R9 we", mem_we, 1);
        cyc(1); commit = 1'b0;
        cnt = 0;
        while (wr_busy === 1'b1 && cnt < 10 * WR_CYC) begin
            cnt++;
            if (cnt == 5) begin
                commit = 1'b1; slv_pull = 1'b1; #1;
                chk("R10 we", mem_we, 0);
                chk("R10 line", sda_pull, 0);
                chk("R10 slv_en", slv_en, 0);
            end
            cyc(1);
            commit = 1'b0; slv_pull = 1'b0;
        end
        chk("R9 window", cnt, WR_CYC);
        chk("R10 slv_en after", slv_en, 1);

        // R9: a second write is accepted after the window
        commit = 1'b1; #1;
        chk("R9 second we", mem_we, 1);
        cyc(1); commit = 1'b0;
        chk("R9 second busy", wr_busy, 1);
        cyc(WR_CYC + 2);
        chk("R9 idle", wr_busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule